// File: doc/BRIEF.md
# I2C Register Slave with Repeated-Write Mode

This block is a two-wire serial slave that fronts a small bank of 8-bit registers. It watches the clock and data lines through synchronizers running on a faster system clock, finds START and STOP, checks the 7-bit device address, acknowledges bytes by pulling the data line low, and turns the bytes that follow into register writes. Each write also appears on the ports as a one-clock strobe carrying the register address and data, so neighbouring logic can react to it.

Writes come in two shapes, chosen by a mode input. In the streaming shape, one register address is followed by any number of data bytes, and the address moves up by one after each byte. In the paired shape, every data byte is preceded by its own register address, so a single transaction can update scattered registers. A read transaction returns register contents starting at the current pointer, with the pointer moving up after each byte.

Top module: `i2c_rw_slave`

## Requirements
- R1: A frame whose first byte after START carries the device address (bits 7..1, default 0x42) acknowledges that byte by driving the data line low in the ninth clock; any other device address gets no acknowledge, and every later byte of that frame is neither acknowledged nor written.
- R2: In a write frame (bit 0 of the first byte low), the second byte is acknowledged and becomes the register pointer.
- R3: With `mode_rep` low, each further data byte is acknowledged and written to the pointer, which then increments by one (modulo 256).
- R4: With `mode_rep` high, the bytes after the first register address alternate data, address, data, ...; each data byte is written to the address that came just before it.
- R5: Each written byte raises `wr_stb` for exactly one system clock, with `wr_addr`/`wr_data` holding the target address and byte, in the same clock that the acknowledge for that byte starts driving the line.
- R6: A START or STOP inside a byte abandons the frame: the partial byte is not written, and a following START begins a fresh device-address byte.
- R7: After any START or STOP the slave releases the data line (`sda_oe` low), and the line driver never changes while the clock line stays high except just after START or STOP.
- R8: In a read frame (bit 0 of the first byte high), the slave sends the register at the pointer, most significant bit first, and keeps sending the next register while the master acknowledges; after a master no-acknowledge it leaves the line released until the next START or STOP.
- R9: Addresses at or above DEPTH (default 16) still raise the strobe, but nothing is stored there and reads of them return 0x00.
- R10: After reset every register reads 0x00, `sda_oe` is low and `wr_stb` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| mode_rep | input | 1 | 1: address/data pairs; 0: auto-incrementing burst |
| sda_oe | output | 1 | 1 pulls the data line low (open-drain enable) |
| wr_stb | output | 1 | One-clock write strobe |
| wr_addr | output | 8 | Register address of the strobed write |
| wr_data | output | 8 | Data byte of the strobed write |

## Verification
Streaming bursts and paired bursts of random length, address and data are run against a bench model of the bank, which separates an incrementing pointer from a pointer reloaded by every other byte. Frames to a foreign device address show that nothing is acknowledged or stored, and bytes cut short by STOP or a repeated START show that a partial byte never reaches the bank. Reads with a final no-acknowledge followed by extra clocks, and reads of addresses past the bank, separate a slave that keeps driving from one that lets go and separate stored from absent registers.

// File: rtl/i2c_rw_pkg.sv
package i2c_rw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_SKIP
    } bus_st_e;

    typedef enum logic [1:0] {
        PH_DEV,
        PH_REG,
        PH_DATA
    } rx_ph_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_ev_t;

    typedef struct packed {
        logic       valid;
        logic [7:0] addr;
        logic [7:0] data;
    } wr_req_t;

    function automatic logic dev_match(input logic [7:0] first, input logic [6:0] own);
        return first[7:1] == own;
    endfunction

endpackage

// File: rtl/rw_line_sync.sv
module rw_line_sync
    import i2c_rw_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic              scl_q, sda_q;
    logic              scl_s, sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_s;
            sda_q    <= sda_s;
        end
    end

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    always_comb begin
        ev.scl      = scl_s;
        ev.sda      = sda_s;
        ev.scl_rise = scl_s & ~scl_q;
        ev.scl_fall = ~scl_s & scl_q;
        ev.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/rw_byte_fsm.sv
module rw_byte_fsm
    import i2c_rw_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h42
) (
    input  logic       clk,
    input  logic       rst,
    input  line_ev_t   ev,
    input  logic       mode_rep,
    input  logic [7:0] rd_data,
    output logic [7:0] rd_addr,
    output logic       sda_oe,
    output wr_req_t    wr
);
    bus_st_e    st;
    rx_ph_e     ph;
    logic [2:0] cnt;
    logic [7:0] sh, tx, ptr;
    logic       full, rd_dir, more;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            ph     <= PH_DEV;
            cnt    <= '0;
            sh     <= '0;
            tx     <= '0;
            ptr    <= '0;
            full   <= 1'b0;
            rd_dir <= 1'b0;
            more   <= 1'b0;
            wr     <= '0;
        end else begin
            wr.valid <= 1'b0;
            if (ev.stop) begin
                st <= ST_IDLE;
            end else if (ev.start) begin
                st   <= ST_RX;
                ph   <= PH_DEV;
                cnt  <= '0;
                full <= 1'b0;
            end else begin
                unique case (st)
                    ST_RX: begin
                        if (ev.scl_rise) begin
                            sh   <= {sh[6:0], ev.sda};
                            cnt  <= cnt + 3'd1;
                            full <= (cnt == 3'd7);
                        end else if (ev.scl_fall && full) begin
                            full <= 1'b0;
                            unique case (ph)
                                PH_DEV: begin
                                    if (dev_match(sh, DEV_ADDR)) begin
                                        rd_dir <= sh[0];
                                        ph     <= PH_REG;
                                        st     <= ST_ACK;
                                    end else begin
                                        st <= ST_SKIP;
                                    end
                                end
                                PH_REG: begin
                                    ptr <= sh;
                                    ph  <= PH_DATA;
                                    st  <= ST_ACK;
                                end
                                default: begin
                                    wr.valid <= 1'b1;
                                    wr.addr  <= ptr;
                                    wr.data  <= sh;
                                    st       <= ST_ACK;
                                    if (mode_rep) ph  <= PH_REG;
                                    else          ptr <= ptr + 8'd1;
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (ev.scl_fall) begin
                            cnt <= '0;
                            if (rd_dir) begin
                                st  <= ST_TX;
                                tx  <= rd_data;
                                ptr <= ptr + 8'd1;
                            end else begin
                                st <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (ev.scl_fall) begin
                            if (cnt == 3'd7) begin
                                st <= ST_MACK;
                            end else begin
                                tx  <= {tx[6:0], 1'b0};
                                cnt <= cnt + 3'd1;
                            end
                        end
                    end
                    ST_MACK: begin
                        if (ev.scl_rise) begin
                            more <= ~ev.sda;
                        end else if (ev.scl_fall) begin
                            if (more) begin
                                st  <= ST_TX;
                                tx  <= rd_data;
                                ptr <= ptr + 8'd1;
                                cnt <= '0;
                            end else begin
                                st <= ST_SKIP;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rd_addr = ptr;
    assign sda_oe  = (st == ST_ACK) || (st == ST_TX && !tx[7]);

    p_strobe_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        wr.valid |=> !wr.valid);

    p_strobe_in_ack_r5: assert property (@(posedge clk) disable iff (rst)
        wr.valid |-> sda_oe);

    p_stop_release_r7: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> !sda_oe);

    p_start_release_r7: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> !sda_oe);

    p_oe_steady_high_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(ev.scl) && ev.scl && !$past(ev.start || ev.stop)) |-> $stable(sda_oe));

endmodule

// File: rtl/rw_reg_bank.sv
module rw_reg_bank
    import i2c_rw_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  wr_req_t    wr,
    input  logic [7:0] rd_addr,
    output logic [7:0] rd_data
);
    localparam int         IW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [8:0] LIM = 9'(DEPTH);

    logic [DEPTH-1:0][7:0] mem;
    logic                  wr_hit, rd_hit;

    assign wr_hit = wr.valid && ({1'b0, wr.addr} < LIM);
    assign rd_hit = {1'b0, rd_addr} < LIM;

    for (genvar g = 0; g < DEPTH; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)                                   mem[g] <= '0;
            else if (wr_hit && wr.addr[IW-1:0] == IW'(g)) mem[g] <= wr.data;
        end
    end

    assign rd_data = rd_hit ? mem[rd_addr[IW-1:0]] : 8'h00;

    p_bank_store_r9: assert property (@(posedge clk) disable iff (rst)
        wr_hit |=> mem[$past(wr.addr[IW-1:0])] == $past(wr.data));

endmodule

// File: rtl/i2c_rw_slave.sv
module i2c_rw_slave
    import i2c_rw_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h42,
    parameter int         DEPTH       = 16,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       mode_rep,
    output logic       sda_oe,
    output logic       wr_stb,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data
);
    line_ev_t   ev;
    wr_req_t    wr;
    logic [7:0] rd_addr, rd_data;

    rw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    rw_byte_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .mode_rep (mode_rep),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .sda_oe   (sda_oe),
        .wr       (wr)
    );

    rw_reg_bank #(.DEPTH(DEPTH)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    assign wr_stb  = wr.valid;
    assign wr_addr = wr.addr;
    assign wr_data = wr.data;

    p_reset_quiet_r10: assert property (@(posedge clk)
        $past(rst) |-> (!wr_stb && !sda_oe));

endmodule

// File: tb/i2c_rw_slave_test.sv
module i2c_rw_slave_test;
    localparam int         Q     = 8;
    localparam int         DEPTH = 16;
    localparam logic [6:0] DEV   = 7'h42;

    logic clk = 1'b0, rst = 1'b1, scl = 1'b1, sda_m = 1'b1, mode_rep = 1'b0;
    logic sda_oe, wr_stb, sda_bus;
    logic [7:0] wr_addr, wr_data;

    assign sda_bus = sda_m & ~sda_oe;
    always #2 clk = ~clk;

    i2c_rw_slave #(.DEV_ADDR(DEV), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus), .mode_rep(mode_rep),
        .sda_oe(sda_oe), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    int checks = 0, errors = 0, misalign = 0;
    logic [7:0] model [256];
    logic [7:0] la[$], ld[$], ea[$], ed[$];
    logic [7:0] ta [16], td [16], rb [16];
    logic       all_ack;

    always @(negedge clk) if (!rst && wr_stb) begin
        la.push_back(wr_addr);
        ld.push_back(wr_data);
        if (!sda_oe) misalign++;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2 * Q);
    endtask

    task automatic bit_out(input logic b);
        sda_m = b; tick(Q); scl = 1'b1; tick(2 * Q); scl = 1'b0; tick(Q);
    endtask

    task automatic send(input logic [7:0] v, output logic ack);
        for (int i = 7; i >= 0; i--) bit_out(v[i]);
        sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
        ack = !sda_bus;
        tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic recv(input logic m_ack, output logic [7:0] v);
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick(Q); scl = 1'b1; tick(Q);
            v = {v[6:0], sda_bus};
            tick(Q); scl = 1'b0; tick(Q);
        end
        bit_out(!m_ack);
        sda_m = 1'b1;
    endtask

    task automatic send_all(input logic [7:0] v);
        logic a;
        send(v, a);
        all_ack = all_ack & a;
    endtask

    task automatic expect_wr(input logic [7:0] a, input logic [7:0] d);
        ea.push_back(a); ed.push_back(d);
        if (a < DEPTH) model[a] = d;
    endtask

    task automatic check_log(input string req);
        int bad = 0;
        chk(req, la.size(), ea.size());
        if (la.size() == ea.size())
            for (int i = 0; i < la.size(); i++)
                if (la[i] != ea[i] || ld[i] != ed[i]) bad++;
        chk(req, bad, 0);
        la.delete(); ld.delete(); ea.delete(); ed.delete();
    endtask

    // streaming write: ta[0] start address, td[0..n-1] data (R2, R3)
    task automatic wr_stream(input int n);
        mode_rep = 1'b0; all_ack = 1'b1;
        i2c_start(); send_all({DEV, 1'b0}); send_all(ta[0]);
        for (int i = 0; i < n; i++) begin
            send_all(td[i]);
            expect_wr(ta[0] + 8'(i), td[i]);
        end
        i2c_stop();
    endtask

    // paired write: (ta[i], td[i]) for i < n (R4)
    task automatic wr_pairs(input int n);
        mode_rep = 1'b1; all_ack = 1'b1;
        i2c_start(); send_all({DEV, 1'b0});
        for (int i = 0; i < n; i++) begin
            send_all(ta[i]); send_all(td[i]);
            expect_wr(ta[i], td[i]);
        end
        i2c_stop();
    endtask

    task automatic rd_frame(input logic [7:0] a, input int n);
        all_ack = 1'b1;
        i2c_start(); send_all({DEV, 1'b0}); send_all(a);
        i2c_start(); send_all({DEV, 1'b1});
        for (int i = 0; i < n; i++) recv(i != n - 1, rb[i]);
        i2c_stop();
    endtask

    task automatic check_bank(input string req);
        int bad = 0;
        rd_frame(8'h00, DEPTH);
        for (int i = 0; i < DEPTH; i++) if (rb[i] != model[i]) bad++;
        chk(req, bad, 0);
        chk(req, all_ack, 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic a;
        logic [7:0] v;
        void'($urandom(32'd4711));
        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        tick(5); rst = 1'b0; tick(3);

        chk("R10 sda_oe", sda_oe, 0);
        chk("R10 wr_stb", wr_stb, 0);
        check_bank("R10 reset contents");

        // R3 streaming burst
        ta[0] = 8'h03; td[0] = 8'hA5; td[1] = 8'h3C; td[2] = 8'h81;
        wr_stream(3);
        chk("R2 R3 acks", all_ack, 1);
        check_log("R3 R5 strobes");
        chk("R7 released after stop", sda_oe, 0);

        // R4 paired burst, scattered addresses
        ta[0] = 8'h0E; td[0] = 8'h11; ta[1] = 8'h01; td[1] = 8'h22;
        ta[2] = 8'h09; td[2] = 8'h33; ta[3] = 8'h0E; td[3] = 8'h44;
        wr_pairs(4);
        chk("R4 acks", all_ack, 1);
        check_log("R4 R5 strobes");
        check_bank("R4 readback");

        // R1 foreign device address
        i2c_start();
        send({DEV ^ 7'h01, 1'b0}, a); chk("R1 foreign addr nack", a, 0);
        send(8'h03, a);               chk("R1 ignored reg byte", a, 0);
        send(8'h99, a);               chk("R1 ignored data byte", a, 0);
        i2c_stop();
        check_log("R1 no strobes");

        // R6 partial byte cut by STOP
        mode_rep = 1'b0;
        i2c_start(); send({DEV, 1'b0}, a); send(8'h05, a);
        for (int i = 0; i < 4; i++) bit_out(1'b1);
        i2c_stop();
        check_log("R6 stop abandons");
        // R6 partial byte cut by START, then fresh frame
        i2c_start(); send({DEV, 1'b0}, a); send(8'h06, a);
        for (int i = 0; i < 3; i++) bit_out(1'b1);
        all_ack = 1'b1;
        i2c_start(); send_all({DEV, 1'b0}); send_all(8'h07); send_all(8'h5A);
        expect_wr(8'h07, 8'h5A);
        i2c_stop();
        chk("R6 fresh frame acks", all_ack, 1);
        check_log("R6 start abandons");
        check_bank("R6 readback");

        // R9 out-of-range address
        ta[0] = 8'h40; td[0] = 8'h77;
        wr_pairs(1);
        check_log("R9 strobe out of range");
        rd_frame(8'h40, 2);
        chk("R9 read beyond bank", rb[0], 0);
        chk("R9 read beyond bank +1", rb[1], 0);

        // R8 master NACK ends transmission
        i2c_start(); send({DEV, 1'b0}, a); send(8'h0E, a);
        i2c_start(); send({DEV, 1'b1}, a);
        recv(1'b1, rb[0]); recv(1'b0, rb[1]);
        recv(1'b0, v);
        i2c_stop();
        chk("R8 first byte", rb[0], model[14]);
        chk("R8 second byte", rb[1], model[15]);
        chk("R8 released after nack", v, 8'hFF);

        // R3 R4 random bursts
        for (int k = 0; k < 8; k++) begin
            int n = 1 + int'($urandom_range(3));
            for (int i = 0; i < n; i++) begin
                ta[i] = 8'($urandom_range(19));
                td[i] = 8'($urandom);
            end
            if ($urandom_range(1) == 1) begin
                wr_pairs(n);
                chk("R4 random acks", all_ack, 1);
                check_log("R4 random strobes");
            end else begin
                wr_stream(n);
                chk("R3 random acks", all_ack, 1);
                check_log("R3 random strobes");
            end
        end
        check_bank("R3 R4 R9 random readback");
        chk("R5 strobe with ack", misalign, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule